// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block drives a small accumulator machine from a control store. It keeps a microinstruction counter that points into a 32-word, 24-bit control store, and it decodes the addressed word into nineteen one-bit control lines for the datapath. The low five bits of each word hold a jump address. Three of the control lines tell the sequencer how to find the next word: a conditional branch on the accumulator sign, a dispatch through a 16-entry opcode map, or a halt.

After reset the counter sits at address 0, where the instruction fetch routine begins. The fetch routine ends with a dispatch, and each instruction routine then jumps back to address 0. The datapath supplies the 4-bit opcode of the instruction register and the accumulator sign bit. A halt, or a dispatch on opcode 0, freezes the sequencer until the next reset. The contents of both ROMs are parameters, and the defaults hold the basic eight-instruction microprogram.

Top module: `ucode_seq`

## Requirements
- R1: While `rst_ni` is low and directly after its release, the counter is 0: `ctrl_o` shows the signals of word 0, and `halted_o` and `error_o` are 0.
- R2: `ctrl_o` equals bits 23..5 of the addressed control word, so `ctrl_o[18]` is the PC-increment line (word MSB) and `ctrl_o[0]` is the halt line. Bit 7 of the word is the sign branch, bit 6 the dispatch, bit 5 the halt, and bits 4..0 the jump address.
- R3: A word with branch, dispatch and halt all clear loads its jump address into the counter at the next edge.
- R4: A word with dispatch set loads map[`opcode_i`] into the counter, for a nonzero opcode, ignoring the jump address and the branch bit.
- R5: A word with the branch bit set (and no dispatch) loads the jump address when `acc_sign_i` is 1.
- R6: A word with the branch bit set (and no dispatch) loads the counter plus one when `acc_sign_i` is 0, wrapping from 31 to 0.
- R7: A word with the halt bit set makes `halted_o` 1 from the next edge onward, with `error_o` 0. The halt takes priority over dispatch and jump, and `ctrl_o` is all zero while the sequencer is halted.
- R8: A dispatch word, without halt, seen while `opcode_i` is 0, sets both `error_o` and `halted_o` from the next edge, and `ctrl_o` goes to zero.
- R9: With the default ROMs, the sequence from reset is words 300001, 080002, 818040 (hex), followed by the routine that the map picks (opcode 1 goes to address 3, opcode 7 to address 0f, opcode 8 to address 1f).
- R10: Once halted, `halted_o`, `error_o` and `ctrl_o` do not change under any opcode or sign input until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 4 | Opcode field of the instruction register |
| acc_sign_i | input | 1 | Accumulator sign bit (1 = negative) |
| ctrl_o | output | 19 | Control lines of the current word |
| halted_o | output | 1 | Sequencing has stopped |
| error_o | output | 1 | Stopped on a dispatch with opcode 0 |

## Verification
A bench-built control store tags every word with its own address in the top five control lines, mixes plain jumps, sign branches, dispatches, a plain halt and a halt combined with a dispatch, and uses an arithmetic opcode map. Long walks driven by pseudo-random opcodes and sign bits then show whether the sequencer took the jump, the increment or the map entry at each step. They also show whether halt beats dispatch, and whether a zero opcode gives an error stop instead of a plain stop. A second instance with the default contents runs fetch and dispatch for opcodes 1, 7 (with both sign values), 8 and 0, and checks each control word against the hexadecimal microprogram.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int UADDR_W  = 5;
  localparam int OPC_W    = 4;
  localparam int NUM_CTRL = 19;
  localparam int CS_DEPTH = 1 << UADDR_W;
  localparam int CW_W     = NUM_CTRL + UADDR_W;
  localparam int MAP_DEPTH = 1 << OPC_W;

  // field order is the control-word bit order, MSB first
  typedef struct packed {
    logic inc_pc, ld_pc, en_pc, ld_mar, mem_rd, mem_wr, ld_mdr, en_mdr;
    logic ld_ir, en_ir, ld_acc, en_acc, alu_add, alu_sub, en_alu, ld_b;
    logic br_neg, dispatch, stop;
  } ctrl_t;

  function automatic logic [CS_DEPTH*CW_W-1:0] default_cstore();
    logic [CS_DEPTH*CW_W-1:0] r;
    logic [CW_W-1:0] w;
    r = '0;
    for (int i = 0; i < CS_DEPTH; i++) begin
      case (i)
        0:  w = 24'h300001;
        1:  w = 24'h080002;
        2:  w = 24'h818040;
        3:  w = 24'h104004;
        4:  w = 24'h080005;
        5:  w = 24'h012000;
        6:  w = 24'h104007;
        7:  w = 24'h021008;
        8:  w = 24'h040000;
        9:  w = 24'h00080a;
        10: w = 24'h002200;
        11: w = 24'h00040c;
        12: w = 24'h002200;
        13: w = 24'h001100;
        14: w = 24'h404000;
        15: w = 24'h000091;
        17: w = 24'h404000;
        30: w = 24'hffffff;
        31: w = 24'h000020;
        default: w = '0;
      endcase
      r[i*CW_W +: CW_W] = w;
    end
    return r;
  endfunction

  function automatic logic [MAP_DEPTH*UADDR_W-1:0] default_map();
    logic [MAP_DEPTH*UADDR_W-1:0] r;
    logic [UADDR_W-1:0] a;
    for (int i = 0; i < MAP_DEPTH; i++) begin
      case (i)
        0: a = 5'h00;
        1: a = 5'h03;
        2: a = 5'h06;
        3: a = 5'h09;
        4: a = 5'h0b;
        5: a = 5'h0d;
        6: a = 5'h0e;
        7: a = 5'h0f;
        default: a = 5'h1f;
      endcase
      r[i*UADDR_W +: UADDR_W] = a;
    end
    return r;
  endfunction
endpackage

// File: rtl/seq_rom.sv
module seq_rom #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [(1<<AW)*DW-1:0] INIT = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign mem[g] = INIT[g*DW +: DW];
  end

  assign data_o = mem[addr_i];
endmodule

// File: rtl/seq_next.sv
module seq_next #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] upc_i,
  input  logic [AW-1:0] jump_i,
  input  logic [AW-1:0] map_addr_i,
  input  logic          br_neg_i,
  input  logic          dispatch_i,
  input  logic          stop_i,
  input  logic          sign_i,
  input  logic          opc_zero_i,
  output logic [AW-1:0] next_o,
  output logic          halt_o,
  output logic          fault_o
);
  logic [AW-1:0] seq_addr;

  // order: branch/jump, then dispatch, then halt (later wins)
  always_comb begin
    seq_addr = (br_neg_i && !sign_i) ? upc_i + AW'(1) : jump_i;
    fault_o  = 1'b0;
    halt_o   = 1'b0;
    next_o   = seq_addr;
    if (dispatch_i) begin
      if (opc_zero_i) begin
        fault_o = 1'b1;
        halt_o  = 1'b1;
        next_o  = upc_i;
      end else begin
        next_o = map_addr_i;
      end
    end
    if (stop_i) begin
      fault_o = 1'b0;
      halt_o  = 1'b1;
      next_o  = upc_i;
    end
  end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import seq_pkg::*;
#(
  parameter int AW = UADDR_W,
  parameter int OW = OPC_W,
  parameter logic [(1<<AW)*(NUM_CTRL+AW)-1:0] CS_INIT  = default_cstore(),
  parameter logic [(1<<OW)*AW-1:0]            MAP_INIT = default_map()
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [OW-1:0]       opcode_i,
  input  logic                acc_sign_i,
  output logic [NUM_CTRL-1:0] ctrl_o,
  output logic                halted_o,
  output logic                error_o
);
  localparam int CW = NUM_CTRL + AW;

  logic [AW-1:0] upc_q, upc_d, map_addr;
  logic [CW-1:0] cw;
  ctrl_t         sig;
  logic          halt_d, fault_d, halted_q, error_q;

  seq_rom #(.DW(CW), .AW(AW), .INIT(CS_INIT)) u_cstore (
    .addr_i (upc_q),
    .data_o (cw)
  );

  seq_rom #(.DW(AW), .AW(OW), .INIT(MAP_INIT)) u_map (
    .addr_i (opcode_i),
    .data_o (map_addr)
  );

  assign sig = ctrl_t'(cw[CW-1 -: NUM_CTRL]);

  seq_next #(.AW(AW)) u_next (
    .upc_i      (upc_q),
    .jump_i     (cw[AW-1:0]),
    .map_addr_i (map_addr),
    .br_neg_i   (sig.br_neg),
    .dispatch_i (sig.dispatch),
    .stop_i     (sig.stop),
    .sign_i     (acc_sign_i),
    .opc_zero_i (opcode_i == '0),
    .next_o     (upc_d),
    .halt_o     (halt_d),
    .fault_o    (fault_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upc_q    <= '0;
      halted_q <= 1'b0;
      error_q  <= 1'b0;
    end else if (!halted_q) begin
      upc_q    <= upc_d;
      halted_q <= halt_d;
      error_q  <= fault_d;
    end
  end

  assign ctrl_o   = halted_q ? '0 : cw[CW-1 -: NUM_CTRL];
  assign halted_o = halted_q;
  assign error_o  = error_q;
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk
  import seq_pkg::*;
#(
  parameter int AW = UADDR_W,
  parameter int OW = OPC_W
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [OW-1:0]          opcode_i,
  input logic                   acc_sign_i,
  input logic [AW-1:0]          upc_i,
  input logic [NUM_CTRL+AW-1:0] cw_i,
  input logic [AW-1:0]          map_addr_i,
  input logic [NUM_CTRL-1:0]    ctrl_o,
  input logic                   halted_o,
  input logic                   error_o
);
  logic w_cd, w_map, w_hlt;
  logic [AW-1:0] w_jmp;
  assign w_hlt = cw_i[AW];
  assign w_map = cw_i[AW+1];
  assign w_cd  = cw_i[AW+2];
  assign w_jmp = cw_i[AW-1:0];

  p_jump_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && !w_cd && !w_map && !w_hlt) |=> (upc_i == $past(w_jmp)));

  p_dispatch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && w_map && !w_hlt && opcode_i != '0) |=> (upc_i == $past(map_addr_i)));

  p_br_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && w_cd && !w_map && !w_hlt && acc_sign_i) |=> (upc_i == $past(w_jmp)));

  p_br_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && w_cd && !w_map && !w_hlt && !acc_sign_i) |=> (upc_i == $past(upc_i) + AW'(1)));

  p_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && w_hlt) |=> (halted_o && !error_o && ctrl_o == '0));

  p_opc_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_o && w_map && !w_hlt && opcode_i == '0) |=> (halted_o && error_o));

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(error_o) && $stable(upc_i)));
endmodule

bind ucode_seq ucode_seq_chk #(.AW(AW), .OW(OW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .opcode_i   (opcode_i),
  .acc_sign_i (acc_sign_i),
  .upc_i      (upc_q),
  .cw_i       (cw),
  .map_addr_i (map_addr),
  .ctrl_o     (ctrl_o),
  .halted_o   (halted_o),
  .error_o    (error_o)
);

// File: tb/tb_ucode_seq.sv
`timescale 1ns/1ps
module tb_ucode_seq;
  import seq_pkg::*;

  localparam int AW = 5;
  localparam int OW = 4;
  localparam int CW = 24;
  localparam int DEPTH = 32;

  // Bench store: bits 23..19 carry the address, so ctrl_o identifies the counter.
  function automatic logic [CW-1:0] tw(input int a);
    logic [CW-1:0] w;
    int j;
    logic cd, mp, h;
    cd = 0; mp = 0; h = 0;
    if (a == 23) begin h = 1; j = (a + 2) % 32; end
    else if (a == 27) begin h = 1; mp = 1; j = 4; end
    else if (a % 4 == 1 || a == 31) begin cd = 1; j = (a + 9) % 32; end
    else if (a % 4 == 0) j = (a * 7 + 3) % 32;
    else if (a % 4 == 2) begin mp = 1; j = (a + 5) % 32; end
    else j = (a * 3 + 1) % 32;
    w[23:19] = a[4:0];
    w[18:8]  = 11'((a * 37 + 5) & 32'h7ff);
    w[7] = cd; w[6] = mp; w[5] = h;
    w[4:0] = j[4:0];
    return w;
  endfunction

  function automatic logic [AW-1:0] tm(input int op);
    int v;
    v = (op == 0) ? 0 : (op * 5 + 1) % 32;
    return v[4:0];
  endfunction

  function automatic logic [DEPTH*CW-1:0] build_cs();
    logic [DEPTH*CW-1:0] r;
    for (int i = 0; i < DEPTH; i++) r[i*CW +: CW] = tw(i);
    return r;
  endfunction

  function automatic logic [16*AW-1:0] build_map();
    logic [16*AW-1:0] r;
    for (int i = 0; i < 16; i++) r[i*AW +: AW] = tm(i);
    return r;
  endfunction

  localparam logic [DEPTH*CW-1:0] TB_CS  = build_cs();
  localparam logic [16*AW-1:0]    TB_MAP = build_map();

  logic clk = 0;
  logic rst_n = 0;
  logic [OW-1:0] op = '0;
  logic sign = 0;
  logic [18:0] ctrl;
  logic halted, err;
  logic [OW-1:0] d_op = '0;
  logic d_sign = 0;
  logic [18:0] d_ctrl;
  logic d_halted, d_err;

  int checks = 0;
  int failures = 0;
  logic [15:0] lfsr = 16'hace1;

  always #2 clk = ~clk;

  ucode_seq #(.CS_INIT(TB_CS), .MAP_INIT(TB_MAP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(op), .acc_sign_i(sign),
    .ctrl_o(ctrl), .halted_o(halted), .error_o(err)
  );

  ucode_seq dut_def (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(d_op), .acc_sign_i(d_sign),
    .ctrl_o(d_ctrl), .halted_o(d_halted), .error_o(d_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  // default contents: fetch then routine
  task automatic def_run(input logic [3:0] o, input logic s, input logic [CW-1:0] exp [8],
                         input int n, input logic stop, input logic fault);
    d_op = o; d_sign = s;
    do_reset();
    for (int k = 0; k < n; k++) begin
      check("R9 default word", 32'(d_ctrl), 32'(exp[k][23:5]));
      @(negedge clk);
    end
    if (stop) begin
      check("R7/R8 default stop", 32'(d_halted), 32'd1);
      check("R8 default error flag", 32'(d_err), 32'(fault));
      check("R7 default ctrl quiet", 32'(d_ctrl), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [CW-1:0] e [8];
    // R1: during and after reset
    #1;
    check("R1 ctrl in reset", 32'(ctrl), 32'(tw(0)[23:5]));
    check("R1 halted in reset", 32'(halted), 32'd0);
    do_reset();
    check("R1 ctrl after reset", 32'(ctrl), 32'(tw(0)[23:5]));
    check("R1 halted after reset", 32'(halted), 32'd0);
    check("R1 error after reset", 32'(err), 32'd0);

    // R9 default microprogram
    e = '{24'h300001, 24'h080002, 24'h818040, 24'h104004, 24'h080005, 24'h012000, 24'h300001, 24'h0};
    def_run(4'h1, 1'b0, e, 7, 1'b0, 1'b0);
    e = '{24'h300001, 24'h080002, 24'h818040, 24'h000091, 24'h404000, 24'h300001, 24'h0, 24'h0};
    def_run(4'h7, 1'b1, e, 6, 1'b0, 1'b0);
    e = '{24'h300001, 24'h080002, 24'h818040, 24'h000091, 24'h000000, 24'h300001, 24'h0, 24'h0};
    def_run(4'h7, 1'b0, e, 6, 1'b0, 1'b0);
    e = '{24'h300001, 24'h080002, 24'h818040, 24'h000020, 24'h0, 24'h0, 24'h0, 24'h0};
    def_run(4'h8, 1'b0, e, 4, 1'b1, 1'b0);
    e = '{24'h300001, 24'h080002, 24'h818040, 24'h0, 24'h0, 24'h0, 24'h0, 24'h0};
    def_run(4'h0, 1'b0, e, 3, 1'b1, 1'b1);

    // walks over the bench store
    for (int ep = 0; ep < 60; ep++) begin
      int cur;
      string why;
      do_reset();
      cur = 0;
      why = "R1";
      for (int cyc = 0; cyc < 80; cyc++) begin
        logic [CW-1:0] w;
        logic stop, fault;
        int nxt;
        w = tw(cur);
        check({why, " ctrl/R2 word"}, 32'(ctrl), 32'(w[23:5]));
        check({why, " not halted"}, 32'(halted), 32'd0);
        step_lfsr();
        op = (lfsr[4:0] == 5'd0) ? 4'h0 : ((lfsr[11:8] == 4'h0) ? 4'h1 : lfsr[11:8]);
        sign = lfsr[6];
        stop = 0; fault = 0; nxt = cur;
        if (w[5]) begin stop = 1; why = "R7"; end
        else if (w[6] && op == 0) begin stop = 1; fault = 1; why = "R8"; end
        else if (w[6]) begin nxt = int'(tm(int'(op))); why = "R4"; end
        else if (w[7] && sign) begin nxt = int'(w[4:0]); why = "R5"; end
        else if (w[7]) begin nxt = (cur + 1) % 32; why = "R6"; end
        else begin nxt = int'(w[4:0]); why = "R3"; end
        @(negedge clk);
        if (stop) begin
          check({why, " halted"}, 32'(halted), 32'd1);
          check({why, " error"}, 32'(err), 32'(fault));
          check({why, " ctrl quiet"}, 32'(ctrl), 32'd0);
          for (int k = 0; k < 3; k++) begin
            step_lfsr();
            op = lfsr[3:0];
            sign = lfsr[9];
            @(negedge clk);
            check("R10 halted held", 32'(halted), 32'd1);
            check("R10 error held", 32'(err), 32'(fault));
            check("R10 ctrl held", 32'(ctrl), 32'd0);
          end
          break;
        end
        cur = nxt;
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule